// File: doc/BRIEF.md
# Configurable Four-Input Logic Tile

This block is a fine-grained programmable logic cell. It has four data inputs and one output. A static configuration word sets its behaviour. The cell can be a combinational function of three inputs, a gated latch, an edge-triggered D flip-flop, or a D flip-flop with an enable. Each storage mode also has an asynchronous force to 0 or to 1.

Every input first passes through a programmable inverter. This lets the cell absorb polarity changes made elsewhere in a netlist. The role of each inverted input depends on the mode. In particular, the fourth input carries the force signal only when the enable flip-flop is selected. A dedicated `clk` pin serves as the clock in the flip-flop modes and as the gate in latch mode.

Top module: `logic_tile4`

## Requirements
- R1: With `cfg_mode` = 00, `q_out` equals `cfg_tt[{v[2],v[1],v[0]}]` at all times, where `v = in_d ^ cfg_inv`; `v[3]` has no effect in this mode.
- R2: Bit k of `cfg_inv` inverts `in_d[k]` before that input is used in any mode; every role below refers to the inverted value `v`.
- R3: With `cfg_mode` = 01 (latch), `q_out` follows `v[0]` while `clk` is high and holds its value while `clk` is low.
- R4: With `cfg_mode` = 10 (flip-flop), `q_out` takes `v[0]` at each rising edge of `clk`.
- R5: The force input is `v[1]` in modes 01 and 10 and `v[3]` in mode 11. While it is 1, `q_out` is driven at once to `cfg_set_sel` (1 means set, 0 means clear). It overrides data, enable, clock and gate.
- R6: With `cfg_mode` = 11 (enabled flip-flop), `v[1]` is the enable: a rising `clk` edge loads `v[0]` only when the enable is 1, otherwise the value is held.
- R7: While `rst_n` is low, both stored values are 0 asynchronously, so `q_out` is 0 in every storage mode.
- R8: The flip-flop keeps its value while the cell is in mode 00 or 01 and clock edges occur. Returning to mode 10 shows that value until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for flip-flop modes, gate for latch mode |
| rst_n | input | 1 | Asynchronous active-low global reset |
| in_d | input | 4 | Logic inputs before polarity adjustment |
| cfg_tt | input | 8 | Truth table for mode 00 |
| cfg_mode | input | 2 | 00 combinational, 01 latch, 10 flip-flop, 11 enabled flip-flop |
| cfg_inv | input | 4 | Per-input inversion mask |
| cfg_set_sel | input | 1 | Force value: 1 set, 0 clear |
| q_out | output | 1 | Cell output |

## Verification
The hardest case to reach is a force arriving in the middle of a phase, with no clock edge near it. One example is a clear raised while the latch gate is low. Another is a data change while the gate is low, which must not pass through.

To create these cases, the stimulus changes inputs a second time, in the low half of the clock. It then samples a few nanoseconds later, before the next rising edge. Force pulses in the flip-flop modes are held across an edge, so the check can show that the force beats a simultaneous capture.

// File: rtl/logic_tile4.sv
module logic_tile4 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] in_d,
  input  logic [7:0] cfg_tt,
  input  logic [1:0] cfg_mode,
  input  logic [3:0] cfg_inv,
  input  logic       cfg_set_sel,
  output logic       q_out
);
  localparam logic [1:0] M_COMB  = 2'b00;
  localparam logic [1:0] M_LATCH = 2'b01;
  localparam logic [1:0] M_DFF   = 2'b10;
  localparam logic [1:0] M_EDFF  = 2'b11;

  logic [3:0] v;
  logic       comb_y, lat_sc, ff_sc, ff_en, ff_aset, ff_aclr;
  logic       lat_q, ff_q;

  assign v       = in_d ^ cfg_inv;
  assign comb_y  = cfg_tt[v[2:0]];
  assign lat_sc  = (cfg_mode == M_LATCH) & v[1];
  assign ff_sc   = ((cfg_mode == M_DFF) & v[1]) | ((cfg_mode == M_EDFF) & v[3]);
  assign ff_en   = (cfg_mode == M_DFF) | ((cfg_mode == M_EDFF) & v[1]);
  assign ff_aset = ff_sc & cfg_set_sel;
  assign ff_aclr = ff_sc & ~cfg_set_sel;

  always_latch begin
    if (!rst_n)                         lat_q <= 1'b0;
    else if (lat_sc)                    lat_q <= cfg_set_sel;
    else if (cfg_mode == M_LATCH && clk) lat_q <= v[0];
  end

  always_ff @(posedge clk or negedge rst_n or posedge ff_aset or posedge ff_aclr) begin
    if (!rst_n)       ff_q <= 1'b0;
    else if (ff_aclr) ff_q <= 1'b0;
    else if (ff_aset) ff_q <= 1'b1;
    else if (ff_en)   ff_q <= v[0];
  end

  always_comb begin
    case (cfg_mode)
      M_COMB:  q_out = comb_y;
      M_LATCH: q_out = lat_q;
      default: q_out = ff_q;
    endcase
  end

  p_dff_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == M_DFF && !ff_sc) |=> (ff_q == $past(v[0])) || ff_sc);

  p_edff_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == M_EDFF && !ff_en && !ff_sc) |=> $stable(ff_q) || ff_sc);

  p_force_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode[1] && ff_sc && !cfg_set_sel) |-> !q_out);

  p_force_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode[1] && ff_sc && cfg_set_sel) |-> q_out);

  p_latch_open_r3: assert property (@(negedge clk) disable iff (!rst_n)
    (cfg_mode == M_LATCH && !v[1]) |-> (q_out == v[0]));
endmodule

// File: tb/logic_tile4_test.sv
module logic_tile4_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] in_d = 4'h0;
  logic [7:0] cfg_tt = 8'h00;
  logic [1:0] cfg_mode = 2'b10;
  logic [3:0] cfg_inv = 4'h0;
  logic       cfg_set_sel = 1'b0;
  logic       q_out;

  int  n_tot = 0;
  int  n_bad = 0;
  bit  done = 0;
  logic ffm = 1'b0;
  logic latm = 1'b0;

  logic_tile4 uut (.clk(clk), .rst_n(rst_n), .in_d(in_d), .cfg_tt(cfg_tt),
    .cfg_mode(cfg_mode), .cfg_inv(cfg_inv), .cfg_set_sel(cfg_set_sel), .q_out(q_out));

  always #10 clk = ~clk;

  task automatic chk(logic act, logic exp, string tag);
    n_tot++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t act=%b exp=%b", tag, $time, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
    end
  endtask

  task automatic cyc(logic [3:0] i, logic [1:0] m, logic [3:0] iv, logic s,
                     logic [7:0] t, int extra, string tag);
    logic [3:0] vv;
    logic fsc, fen, lsc;
    @(posedge clk);
    vv = in_d ^ cfg_inv;
    fsc = (cfg_mode == 2'b10 && vv[1]) || (cfg_mode == 2'b11 && vv[3]);
    fen = (cfg_mode == 2'b10) || (cfg_mode == 2'b11 && vv[1]);
    if (!fsc && fen) ffm = vv[0];
    if (cfg_mode == 2'b01 && !vv[1]) latm = vv[0];
    #5;
    in_d = i; cfg_mode = m; cfg_inv = iv; cfg_set_sel = s; cfg_tt = t;
    vv = i ^ iv;
    lsc = (m == 2'b01) && vv[1];
    fsc = (m == 2'b10 && vv[1]) || (m == 2'b11 && vv[3]);
    if (m == 2'b01) latm = lsc ? s : vv[0];
    if (fsc) ffm = s;
    #10;
    case (m)
      2'b00:   chk(q_out, t[vv[2:0]], tag);
      2'b01:   chk(q_out, latm, tag);
      default: chk(q_out, ffm, tag);
    endcase
    if (m == 2'b01 && extra == 1) begin
      in_d[0] = ~in_d[0];
      #3 chk(q_out, latm, "R3 hold while gate low");
    end else if (m == 2'b01 && extra == 2 && !lsc) begin
      in_d[1] = ~iv[1];
      latm = s;
      #3 chk(q_out, latm, "R5 latch force while gate low");
    end
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    repeat (2) @(posedge clk);
    #5 chk(q_out, 1'b0, "R7 reset dff mode");
    cfg_mode = 2'b01;
    #1 chk(q_out, 1'b0, "R7 reset latch mode");
    @(posedge clk); #5 rst_n = 1'b1;

    cfg_mode = 2'b00;
    for (int t = 0; t < 256; t++)
      for (int iv = 0; iv < 16; iv++)
        for (int i = 0; i < 16; i++) begin
          logic [3:0] vv;
          cfg_tt = t[7:0]; cfg_inv = iv[3:0]; in_d = i[3:0];
          vv = in_d ^ cfg_inv;
          #1 chk(q_out, cfg_tt[vv[2:0]], "R1 R2 truth table");
        end

    for (int m = 1; m < 4; m++)
      for (int iv = 0; iv < 16; iv++)
        for (int s = 0; s < 2; s++)
          for (int k = 0; k < 12; k++) begin
            logic [3:0] i;
            i = 4'($urandom);
            if ($urandom % 4 != 0) begin
              if (m == 3) i[3] = iv[3];
              else        i[1] = iv[1];
            end
            case (m)
              1:       cyc(i, 2'(m), 4'(iv), s[0], 8'h00, k % 4, "R3 R5 R2 latch");
              2:       cyc(i, 2'(m), 4'(iv), s[0], 8'h00, 0, "R4 R5 R2 dff");
              default: cyc(i, 2'(m), 4'(iv), s[0], 8'h00, 0, "R6 R5 R2 enabled dff");
            endcase
          end

    cyc(4'b0001, 2'b10, 4'h0, 1'b0, 8'h00, 0, "R4 load one");
    cyc(4'b0001, 2'b10, 4'h0, 1'b0, 8'h00, 0, "R4 load one");
    for (int k = 0; k < 4; k++)
      cyc(4'(k * 4), 2'b00, 4'h0, 1'b0, 8'h00, 0, "R1 unused flop");
    cyc(4'b0100, 2'b01, 4'h0, 1'b0, 8'h00, 0, "R3 unused flop");
    cyc(4'b0000, 2'b10, 4'h0, 1'b0, 8'h00, 0, "R8 flop kept");
    chk(q_out, 1'b1, "R8 flop kept value");

    cyc(4'b0001, 2'b10, 4'h0, 1'b0, 8'h00, 0, "R4 before reset");
    @(posedge clk); #5 rst_n = 1'b0;
    #10 chk(q_out, 1'b0, "R7 async reset");
    @(posedge clk); #5 rst_n = 1'b1;
    ffm = 1'b0; latm = 1'b0;
    #10 chk(q_out, 1'b0, "R7 after release");
    cyc(4'b0001, 2'b10, 4'h0, 1'b0, 8'h00, 0, "R4 after reset");
    chk(q_out, 1'b1, "R4 capture after reset");

    finish_run();
  end
endmodule